// File: doc/BRIEF.md
# Early-Terminating Iterative Multiplier

This block is a sequential 32x32 multiplier with an optional accumulate step. Each internal cycle it folds one 8-bit slice of the multiplier into a carry-save pair, starting from the low slice. It stops as soon as every remaining upper multiplier bit equals the extension bit. That bit is the multiplier's sign bit when the operands are signed, and zero when they are unsigned. The top slice is then treated as a signed digit, so the early stop still gives the exact product. When accumulate is selected, one more cycle adds the accumulate operand through the same compressor before the final carry-propagate add.

In short mode only the low 32 bits of the product are produced, and the signed select has no effect. In long mode the 64-bit product is signed or unsigned, and the accumulate operand is the 64-bit value formed from a high word and a low word. The result is returned as a low word and a high word, with a one-cycle done pulse and a count of the internal cycles used.

Requests enter through a valid/ready handshake. A request is taken at a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle, and this includes the cycle in which `done` is high. While `in_ready` is low, `in_valid` and the operand inputs are ignored. The output side has no back-pressure: `done` pulses once, and the result and cycle count hold until the next completion.

Top module: `mul_iter_et`

## Requirements
- R1: With `long_en`=0, `res_lo` equals bits [31:0] of `op_a`*`op_b` (plus `acc_lo` when `acc_en`=1), and it is the same for `sgn_en`=0 and `sgn_en`=1.
- R2: With `long_en`=1 and `sgn_en`=0, {`res_hi`,`res_lo`} is the unsigned 64-bit product of `op_a` and `op_b`.
- R3: With `long_en`=1 and `sgn_en`=1, {`res_hi`,`res_lo`} is the two's-complement 64-bit product of `op_a` and `op_b`.
- R4: With `acc_en`=1, the product gets the accumulate operand added, modulo 2^64 in long mode and modulo 2^32 in short mode. The operand is {`acc_hi`,`acc_lo`} in long mode and `acc_lo` in short mode. The internal cycle count is one higher than without accumulate.
- R5: In short mode and in signed long mode, the multiply takes 1 cycle when `op_b`[31:8] is all zeros or all ones. It takes 2 cycles when `op_b`[31:16] is, 3 cycles when `op_b`[31:24] is, and 4 cycles otherwise.
- R6: In unsigned long mode only all-zero upper bits shorten the multiply. When `op_b`[31:24] is all ones, it takes 4 cycles.
- R7: `done` is high for exactly one cycle. It is high in the cycle after the N-th rising edge following acceptance, where N is the value shown on `cycles`. `res_lo`, `res_hi` and `cycles` change only at the edge that raises `done`.
- R8: `in_ready` is low from the edge after acceptance until the cycle in which `done` is high, and in that cycle it is high again. A request offered while `in_ready` is low does not change the result of the operation in progress.
- R9: After reset, `in_ready`=1, `done`=0, `res_lo`=0, `res_hi`=0 and `cycles`=0.
- R10: In short mode `res_hi` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| op_a | input | 32 | Multiplicand |
| op_b | input | 32 | Multiplier; its upper bits set the cycle count |
| acc_lo | input | 32 | Accumulate operand, low word |
| acc_hi | input | 32 | Accumulate operand, high word (long mode) |
| acc_en | input | 1 | Add the accumulate operand |
| long_en | input | 1 | 1: 64-bit result, 0: low 32 bits only |
| sgn_en | input | 1 | Signed operands in long mode |
| done | output | 1 | One-cycle completion pulse |
| res_lo | output | 32 | Result bits [31:0] |
| res_hi | output | 32 | Result bits [63:32]; zero in short mode |
| cycles | output | 3 | Internal cycles used by the last operation |

## Verification
A completion and a new acceptance can fall in the same cycle: the cycle in which `done` is high also has `in_ready` high, so a request already held on `in_valid` is taken at the very next edge. The bench provokes this by keeping a second request on `in_valid` throughout a five-cycle multiply-accumulate. It checks that the request has no effect while the block is busy, that the first result and cycle count are correct when `done` rises, and that the second request is taken at the following edge with `in_ready` dropping and its own correct result arriving after one cycle.

// File: rtl/mul_et_pkg.sv
package mul_et_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_ACC  = 2'd2
  } mul_state_t;
endpackage

// File: rtl/mul_et_depth.sv
// Decides how many multiplier digits must be processed: the smallest count
// after which every remaining upper bit equals the extension bit.
module mul_et_depth #(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8,
  parameter int CNT_W   = 3
) (
  input  logic [DATA_W-DIGIT_W-1:0] mplier_hi,
  input  logic                      ext,
  output logic [CNT_W-1:0]          n_dig
);
  localparam int N_DIG = DATA_W / DIGIT_W;
  localparam int HI_W  = DATA_W - DIGIT_W;

  logic [N_DIG-1:1] fits;

  for (genvar k = 1; k < N_DIG; k++) begin : g_fit
    assign fits[k] = (mplier_hi[HI_W-1:(k-1)*DIGIT_W] ==
                      {(DATA_W-k*DIGIT_W){ext}});
  end

  always_comb begin
    n_dig = CNT_W'(N_DIG);
    for (int k = N_DIG-1; k >= 1; k--) begin
      if (fits[k]) n_dig = CNT_W'(k);
    end
  end
endmodule

// File: rtl/mul_et_ppgen.sv
// Partial product of the shifted multiplicand and one digit; the digit is
// negative-weighted when it is the last one of a sign-extended multiplier.
module mul_et_ppgen #(
  parameter int DIGIT_W = 8,
  parameter int PROD_W  = 64
) (
  input  logic [PROD_W-1:0]  mcand,
  input  logic [DIGIT_W-1:0] digit,
  input  logic               top_neg,
  output logic [PROD_W-1:0]  pp
);
  logic [PROD_W-1:0] digit_ext;

  assign digit_ext = {{(PROD_W-DIGIT_W){top_neg}}, digit};
  assign pp        = mcand * digit_ext;
endmodule

// File: rtl/mul_et_csa.sv
// Bitwise 3:2 compressor: a + b + c == sum + carry (mod 2^W).
module mul_et_csa #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ c[i];
    if (i > 0) begin : g_cy
      assign carry[i] = (a[i-1] & b[i-1]) | (a[i-1] & c[i-1]) | (b[i-1] & c[i-1]);
    end
  end
endmodule

// File: rtl/mul_iter_et.sv
module mul_iter_et
  import mul_et_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DIGIT_W = 8,
  parameter int CNT_W   = $clog2(DATA_W/DIGIT_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [DATA_W-1:0] acc_lo,
  input  logic [DATA_W-1:0] acc_hi,
  input  logic              acc_en,
  input  logic              long_en,
  input  logic              sgn_en,
  output logic              done,
  output logic [DATA_W-1:0] res_lo,
  output logic [DATA_W-1:0] res_hi,
  output logic [CNT_W-1:0]  cycles
);
  localparam int N_DIG  = DATA_W / DIGIT_W;
  localparam int PROD_W = 2 * DATA_W;

  mul_state_t        state_q;
  logic [PROD_W-1:0] mcand_q, accv_q, sum_q, cry_q;
  logic [DATA_W-1:0] mplier_q;
  logic              ext_q, acc_q, long_q;
  logic [CNT_W-1:0]  ndig_q, k_q, cyc_q;
  logic              done_q;
  logic [DATA_W-1:0] res_lo_q, res_hi_q;

  logic              accept, ext_in, is_last, finish;
  logic [CNT_W-1:0]  ndig_in;
  logic [PROD_W-1:0] pp, third, sum_n, cry_n, total;

  assign in_ready = (state_q == ST_IDLE);
  assign accept   = in_valid && in_ready;
  // extension bit: sign for short and signed long, zero for unsigned long
  assign ext_in   = long_en ? (sgn_en & op_b[DATA_W-1]) : op_b[DATA_W-1];

  mul_et_depth #(.DATA_W(DATA_W), .DIGIT_W(DIGIT_W), .CNT_W(CNT_W)) u_depth (
    .mplier_hi (op_b[DATA_W-1:DIGIT_W]),
    .ext       (ext_in),
    .n_dig     (ndig_in)
  );

  assign is_last = ((k_q + CNT_W'(1)) == ndig_q);

  mul_et_ppgen #(.DIGIT_W(DIGIT_W), .PROD_W(PROD_W)) u_pp (
    .mcand   (mcand_q),
    .digit   (mplier_q[DIGIT_W-1:0]),
    .top_neg (is_last & ext_q),
    .pp      (pp)
  );

  // the accumulate cycle reuses the compressor with the addend in place of a partial product
  assign third = (state_q == ST_ACC) ? accv_q : pp;

  mul_et_csa #(.W(PROD_W)) u_csa (
    .a     (sum_q),
    .b     (cry_q),
    .c     (third),
    .sum   (sum_n),
    .carry (cry_n)
  );

  assign total  = sum_n + cry_n;
  assign finish = ((state_q == ST_RUN) && is_last && !acc_q) || (state_q == ST_ACC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mcand_q  <= '0;
      accv_q   <= '0;
      sum_q    <= '0;
      cry_q    <= '0;
      mplier_q <= '0;
      ext_q    <= 1'b0;
      acc_q    <= 1'b0;
      long_q   <= 1'b0;
      ndig_q   <= '0;
      k_q      <= '0;
      cyc_q    <= '0;
      done_q   <= 1'b0;
      res_lo_q <= '0;
      res_hi_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mcand_q  <= (long_en && sgn_en) ? {{DATA_W{op_a[DATA_W-1]}}, op_a}
                                            : {{DATA_W{1'b0}}, op_a};
            accv_q   <= {(long_en ? acc_hi : {DATA_W{1'b0}}), acc_lo};
            mplier_q <= op_b;
            ext_q    <= ext_in;
            acc_q    <= acc_en;
            long_q   <= long_en;
            ndig_q   <= ndig_in;
            k_q      <= '0;
            sum_q    <= '0;
            cry_q    <= '0;
            state_q  <= ST_RUN;
          end
        end
        ST_RUN: begin
          sum_q    <= sum_n;
          cry_q    <= cry_n;
          mcand_q  <= mcand_q << DIGIT_W;
          mplier_q <= mplier_q >> DIGIT_W;
          k_q      <= k_q + CNT_W'(1);
          if (is_last) state_q <= acc_q ? ST_ACC : ST_IDLE;
        end
        ST_ACC:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      if (finish) begin
        res_lo_q <= total[DATA_W-1:0];
        res_hi_q <= long_q ? total[PROD_W-1:DATA_W] : {DATA_W{1'b0}};
        cyc_q    <= ndig_q + CNT_W'(acc_q);
        done_q   <= 1'b1;
      end
    end
  end

  assign done   = done_q;
  assign res_lo = res_lo_q;
  assign res_hi = res_hi_q;
  assign cycles = cyc_q;

  // R5
  iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (k_q < ndig_q));

  // R5
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((cycles >= CNT_W'(1)) && (cycles <= CNT_W'(N_DIG + 1))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  hold_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_lo) && $stable(res_hi) && $stable(cycles)));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R8
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);

  // R10
  short_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !long_q) |-> (res_hi == '0));
endmodule

// File: tb/mul_iter_et_bench.sv
module mul_iter_et_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] op_a = '0, op_b = '0, acc_lo = '0, acc_hi = '0;
  logic        acc_en = 1'b0, long_en = 1'b0, sgn_en = 1'b0;
  logic        done;
  logic [31:0] res_lo, res_hi;
  logic [2:0]  cycles;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  mul_iter_et u_mul_iter_et (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .acc_lo(acc_lo), .acc_hi(acc_hi),
    .acc_en(acc_en), .long_en(long_en), .sgn_en(sgn_en),
    .done(done), .res_lo(res_lo), .res_hi(res_hi), .cycles(cycles)
  );

  // {a, b, acc_lo, acc_hi, acc_en, long_en, sgn_en, expected cycles}
  localparam int NV = 14;
  localparam logic [133:0] VECS [NV] = '{
    {32'h12345678, 32'h00000005, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 3'd1},
    {32'hFFFFFFF6, 32'hFFFFFFFD, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, 3'd1},
    {32'h89ABCDEF, 32'h0000ABCD, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 3'd2},
    {32'h89ABCDEF, 32'hFFFF8001, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd2},
    {32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, 3'd4},
    {32'h7FFFFFFF, 32'hFFFFFFFF, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd1},
    {32'hDEADBEEF, 32'h00123456, 32'h11111111, 32'h22222222, 1'b1, 1'b1, 1'b1, 3'd4},
    {32'hCAFEBABE, 32'h80000001, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd4},
    {32'h01020304, 32'h12345678, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 1'b0, 3'd5},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b0, 3'd5},
    {32'h00000003, 32'hFF800000, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd3},
    {32'h00000007, 32'h00FF0000, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 3'd3},
    {32'hFFFFFFFF, 32'h0000FF00, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd2},
    {32'h80000000, 32'h00000000, 32'h0, 32'h0, 1'b0, 1'b1, 1'b1, 3'd1}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [31:0] al, input logic [31:0] ah,
                                        input logic acc, input logic lng, input logic sgn);
    logic [63:0] p;
    if (lng) begin
      if (sgn) p = 64'($signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b}));
      else     p = {32'b0, a} * {32'b0, b};
      if (acc) p = p + {ah, al};
    end else begin
      p = {32'b0, a * b + (acc ? al : 32'b0)};
    end
    return p;
  endfunction

  // issue one request from idle and wait for done; lat counts edges after acceptance
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] al,
                        input logic [31:0] ah, input logic acc, input logic lng, input logic sgn,
                        output logic [63:0] r, output logic [2:0] cy, output int lat);
    @(negedge clk);
    op_a = a; op_b = b; acc_lo = al; acc_hi = ah;
    acc_en = acc; long_en = lng; sgn_en = sgn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R8 busy after accept", {63'b0, in_ready}, 64'd0);
    lat = 0;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    r  = {res_hi, res_lo};
    cy = cycles;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [63:0] r, e, r2;
    logic [2:0]  cy;
    int          lat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(in_ready == 1'b1, "R9 in_ready", {63'b0, in_ready}, 64'd1);
    chk(done == 1'b0, "R9 done", {63'b0, done}, 64'd0);
    chk({res_hi, res_lo} == 64'd0, "R9 result", {res_hi, res_lo}, 64'd0);
    chk(cycles == 3'd0, "R9 cycles", {61'b0, cycles}, 64'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [133:0] v;
      string tr, tc;
      v = VECS[i];
      e = model(v[133:102], v[101:70], v[69:38], v[37:6], v[5], v[4], v[3]);
      run_op(v[133:102], v[101:70], v[69:38], v[37:6], v[5], v[4], v[3], r, cy, lat);
      tr = !v[4] ? "R1 short product" : (v[3] ? "R3 signed long" : "R2 unsigned long");
      if (v[5]) tr = "R4 accumulate";
      tc = (v[4] && !v[3]) ? "R6 unsigned early stop" : "R5 cycle count";
      if (v[4]) chk(r == e, tr, r, e);
      else      chk(r[31:0] == e[31:0], tr, r, e);
      if (!v[4]) chk(r[63:32] == 32'd0, "R10 short high word", {32'b0, r[63:32]}, 64'd0);
      chk(cy == v[2:0], tc, {61'b0, cy}, {61'b0, v[2:0]});
      chk(lat == int'(v[2:0]), "R7 latency", 64'(lat), {61'b0, v[2:0]});
      @(negedge clk);
      chk(done == 1'b0, "R7 single pulse", {63'b0, done}, 64'd0);
    end

    // R4: accumulate adds exactly one cycle over the same multiply
    run_op(32'h00000011, 32'h00000022, 32'h0, 32'h0, 1'b0, 1'b1, 1'b0, r, cy, lat);
    run_op(32'h00000011, 32'h00000022, 32'h5, 32'h0, 1'b1, 1'b1, 1'b0, r2, cy, lat);
    chk(cy == 3'd2 && r2 == r + 64'd5, "R4 plus one cycle", {61'b0, cy}, 64'd2);

    // R1: signed select ignored in short mode
    run_op(32'hFFFFFFF6, 32'h00000007, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, r, cy, lat);
    run_op(32'hFFFFFFF6, 32'h00000007, 32'h0, 32'h0, 1'b0, 1'b0, 1'b1, r2, cy, lat);
    chk(r == r2 && r[31:0] == 32'hFFFFFFBA, "R1 sign select ignored", r2, r);

    // R7: result holds while idle
    repeat (5) @(negedge clk);
    chk({res_hi, res_lo} == r2 && cycles == 3'd1, "R7 hold", {res_hi, res_lo}, r2);

    // R8: request held during busy is ignored, then taken in the done cycle
    @(negedge clk);
    op_a = 32'h01020304; op_b = 32'h12345678; acc_lo = 32'hFFFFFFFF; acc_hi = 32'h0;
    acc_en = 1'b1; long_en = 1'b0; sgn_en = 1'b0; in_valid = 1'b1;
    @(negedge clk);
    op_a = 32'h5; op_b = 32'h7; acc_lo = 32'h0; acc_en = 1'b0;
    lat = 0;
    while (!done && lat < 12) begin
      @(negedge clk);
      lat++;
    end
    e = model(32'h01020304, 32'h12345678, 32'hFFFFFFFF, 32'h0, 1'b1, 1'b0, 1'b0);
    chk(res_lo == e[31:0], "R8 busy request ignored", {32'b0, res_lo}, e);
    chk(cycles == 3'd5, "R8 first cycle count", {61'b0, cycles}, 64'd5);
    chk(in_ready == 1'b1, "R8 ready in done cycle", {63'b0, in_ready}, 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0 && done == 1'b0, "R8 taken at done edge", {62'b0, in_ready, done}, 64'd0);
    @(negedge clk);
    chk(done == 1'b1 && res_lo == 32'd35 && cycles == 3'd1, "R8 second result",
        {31'b0, done, res_lo}, {31'b0, 1'b1, 32'd35});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule